// File: doc/BRIEF.md
# Fixed-point RGB to YUV converter

This block turns a stream of pixels, one per clock, from three unsigned 8-bit colour components into luma and two chroma components. Each output channel is a three-term weighted sum of the inputs. The weights are fixed integers scaled by 2^15. The sum is divided by 32768 with an arithmetic right shift, a mid-scale bias of 128 is added to the two chroma channels, and the result is clamped to the 8-bit range.

A producer presents pixels with a valid/ready handshake. The converter never applies backpressure once it is out of reset. Results leave on a valid-qualified output exactly three cycles after the pixel is taken, in the order the pixels arrived. Idle input cycles pass through the pipeline as idle output cycles, and the output data holds its last value across them.

Top module: `rgb_yuv_conv`

## Requirements
- R1: While rst_n is low, out_valid is low, out_y, out_u and out_v are zero, and in_ready is low.
- R2: From the first rising clock edge after rst_n goes high, in_ready stays high, so every in_valid cycle is accepted.
- R3: A pixel accepted at a rising edge (in_valid and in_ready both high) appears with out_valid high after the third following rising edge, and out_valid is high in no other cycle; pixel order is preserved.
- R4: out_y equals floor((9798*R + 19235*G + 3736*B) / 32768), clamped to 0..255; a grey pixel (R = G = B) gives out_y equal to R.
- R5: out_u equals floor((14221*B - 4784*R - 9437*G) / 32768) + 128, clamped to 0..255; a grey pixel gives 128.
- R6: out_v equals floor((20218*R - 16941*G - 3277*B) / 32768) + 128, clamped to 0..255; a grey pixel gives 128.
- R7: A biased result below 0 is output as 0 and one above 255 as 255; for example R=255, G=0, B=0 gives out_v = 255, and R=0, G=255, B=255 gives out_v = 0.
- R8: In any cycle where out_valid is low, out_y, out_u and out_v keep the values they had in the previous cycle.
- R9: The division rounds toward minus infinity, including for negative sums; for example R=1, G=0, B=0 gives out_u = 127 and out_v = 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel is offered on in_r, in_g and in_b |
| in_ready | output | 1 | The converter takes the offered pixel |
| in_r | input | 8 | Red component, unsigned |
| in_g | input | 8 | Green component, unsigned |
| in_b | input | 8 | Blue component, unsigned |
| out_valid | output | 1 | out_y, out_u and out_v carry a new result |
| out_y | output | 8 | Luma result |
| out_u | output | 8 | Blue-difference chroma result, biased by 128 |
| out_v | output | 8 | Red-difference chroma result, biased by 128 |

## Verification
The hard behaviours to reach from the ports are the two clamp directions and the rounding of negative sums. Only the red-difference channel can leave the 8-bit range, and only for strongly red or strongly cyan pixels. Floor rounding of a negative sum differs from truncation only when the sum is not a multiple of 32768. A coarse grid over all three components that includes 0 and 255 on every axis, together with directed pure-red, cyan, near-black and grey pixels, drives both clamp edges and many negative non-exact sums. Random pixels with random idle gaps then check latency, ordering and data hold across bubbles.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int COEF_W = 16;
    localparam int N_CH   = 3;

    typedef logic signed [COEF_W-1:0] coef_t;

    // Weight of one input term for one output channel.
    // ch: 0 = luma, 1 = blue difference, 2 = red difference
    // term: 0 = red, 1 = green, 2 = blue
    function automatic coef_t weight(input int ch, input int term);
        coef_t k;
        k = '0;
        case (ch)
            0: case (term)
                   0: k = 16'sd9798;
                   1: k = 16'sd19235;
                   default: k = 16'sd3736;
               endcase
            1: case (term)
                   0: k = -16'sd4784;
                   1: k = -16'sd9437;
                   default: k = 16'sd14221;
               endcase
            default: case (term)
                   0: k = 16'sd20218;
                   1: k = -16'sd16941;
                   default: k = -16'sd3277;
               endcase
        endcase
        return k;
    endfunction

    // Mid-scale bias added after the shift (chroma channels only).
    function automatic int channel_bias(input int ch, input int pix_w);
        return (ch == 0) ? 0 : (1 << (pix_w - 1));
    endfunction

endpackage

// File: rtl/csc_valid_pipe.sv
module csc_valid_pipe #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    output logic [DEPTH-1:0] stage_v
);

    typedef struct packed {
        logic [DEPTH-1:0] v;
    } vpipe_t;

    vpipe_t vp_d, vp_q;

    always_comb begin
        vp_d = vp_q;
        if (DEPTH > 1) begin
            vp_d.v = {vp_q.v[DEPTH-2:0], take};
        end else begin
            vp_d.v = DEPTH'(take);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vp_q <= '0;
        end else begin
            vp_q <= vp_d;
        end
    end

    assign stage_v = vp_q.v;

endmodule

// File: rtl/csc_clamp.sv
module csc_clamp #(
    parameter int W_IN  = 26,
    parameter int W_OUT = 8
) (
    input  logic signed [W_IN-1:0]  val,
    output logic        [W_OUT-1:0] sat
);

    localparam logic signed [W_IN-1:0] TOP = W_IN'((1 << W_OUT) - 1);

    always_comb begin
        if (val < 0) begin
            sat = '0;
        end else if (val > TOP) begin
            sat = '1;
        end else begin
            sat = val[W_OUT-1:0];
        end
    end

endmodule

// File: rtl/csc_mac_lane.sv
module csc_mac_lane
    import csc_pkg::*;
#(
    parameter int    PIX_W  = 8,
    parameter int    FRAC_W = 15,
    parameter int    ACC_W  = 26,
    parameter coef_t K_R    = '0,
    parameter coef_t K_G    = '0,
    parameter coef_t K_B    = '0,
    parameter int    BIAS   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       stage_en,
    input  logic [PIX_W-1:0] pix_r,
    input  logic [PIX_W-1:0] pix_g,
    input  logic [PIX_W-1:0] pix_b,
    output logic [PIX_W-1:0] res
);

    typedef struct packed {
        logic signed [ACC_W-1:0] p_r;
        logic signed [ACC_W-1:0] p_g;
        logic signed [ACC_W-1:0] p_b;
        logic signed [ACC_W-1:0] acc;
        logic        [PIX_W-1:0] res;
    } lane_t;

    lane_t st_d, st_q;

    logic signed [ACC_W-1:0] acc_s;
    logic signed [ACC_W-1:0] scaled;
    logic        [PIX_W-1:0] clamped;

    function automatic logic signed [ACC_W-1:0] term(input logic [PIX_W-1:0] x,
                                                     input coef_t k);
        logic signed [ACC_W-1:0] xs;
        logic signed [ACC_W-1:0] ks;
        xs = ACC_W'(signed'({1'b0, x}));
        ks = ACC_W'(k);
        return xs * ks;
    endfunction

    assign acc_s  = st_q.acc;
    assign scaled = (acc_s >>> FRAC_W) + ACC_W'(BIAS);

    csc_clamp #(
        .W_IN (ACC_W),
        .W_OUT(PIX_W)
    ) i_clamp (
        .val(scaled),
        .sat(clamped)
    );

    always_comb begin
        st_d = st_q;
        // stage 1: three products
        if (stage_en[0]) begin
            st_d.p_r = term(pix_r, K_R);
            st_d.p_g = term(pix_g, K_G);
            st_d.p_b = term(pix_b, K_B);
        end
        // stage 2: accumulate
        if (stage_en[1]) begin
            st_d.acc = st_q.p_r + st_q.p_g + st_q.p_b;
        end
        // stage 3: shift, bias, clamp
        if (stage_en[2]) begin
            st_d.res = clamped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res = st_q.res;

endmodule

// File: rtl/rgb_yuv_conv.sv
module rgb_yuv_conv
    import csc_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int FRAC_W = 15,
    parameter int ACC_W  = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_r,
    input  logic [PIX_W-1:0] in_g,
    input  logic [PIX_W-1:0] in_b,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_y,
    output logic [PIX_W-1:0] out_u,
    output logic [PIX_W-1:0] out_v
);

    localparam int STAGES = 3;

    typedef struct packed {
        logic ready;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              take;
    logic [STAGES-1:0] stage_v;
    logic [PIX_W-1:0]  lane_res [N_CH];

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ready = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready = ctl_q.ready;
    assign take     = in_valid & ctl_q.ready;

    csc_valid_pipe #(
        .DEPTH(STAGES)
    ) i_valid_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .stage_v(stage_v)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
        csc_mac_lane #(
            .PIX_W (PIX_W),
            .FRAC_W(FRAC_W),
            .ACC_W (ACC_W),
            .K_R   (weight(ch, 0)),
            .K_G   (weight(ch, 1)),
            .K_B   (weight(ch, 2)),
            .BIAS  (channel_bias(ch, PIX_W))
        ) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .stage_en({stage_v[1], stage_v[0], take}),
            .pix_r   (in_r),
            .pix_g   (in_g),
            .pix_b   (in_b),
            .res     (lane_res[ch])
        );
    end

    assign out_valid = stage_v[STAGES-1];
    assign out_y     = lane_res[0];
    assign out_u     = lane_res[1];
    assign out_v     = lane_res[2];

endmodule

// File: rtl/csc_chk.sv
module csc_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [PIX_W-1:0] in_r,
    input logic [PIX_W-1:0] in_g,
    input logic [PIX_W-1:0] in_b,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_y,
    input logic [PIX_W-1:0] out_u,
    input logic [PIX_W-1:0] out_v
);

    localparam logic [PIX_W-1:0] MID = PIX_W'(1 << (PIX_W - 1));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && !in_ready && out_y == '0 && out_u == '0 && out_v == '0));

    // R2
    ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> in_ready);

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && in_ready, 3));

    // R4
    grey_luma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_r, 3) == $past(in_g, 3) && $past(in_g, 3) == $past(in_b, 3))
        |-> out_y == $past(in_r, 3));

    // R5 R6
    grey_chroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_r, 3) == $past(in_g, 3) && $past(in_g, 3) == $past(in_b, 3))
        |-> (out_u == MID && out_v == MID));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable({out_y, out_u, out_v}));

endmodule

bind rgb_yuv_conv csc_chk #(.PIX_W(PIX_W)) i_csc_chk (.*);

// File: tb/test_rgb_yuv_conv.sv
module test_rgb_yuv_conv;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_r, in_g, in_b;
    logic       out_valid;
    logic [7:0] out_y, out_u, out_v;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    typedef struct {
        int r;
        int g;
        int b;
        int stamp;
    } pend_t;

    pend_t pend_q[$];
    int    last_y = 0, last_u = 0, last_v = 0;

    always #4 clk = ~clk;

    rgb_yuv_conv i_rgb_yuv_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_r     (in_r),
        .in_g     (in_g),
        .in_b     (in_b),
        .out_valid(out_valid),
        .out_y    (out_y),
        .out_u    (out_u),
        .out_v    (out_v)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int clamp8(input int x);
        return (x < 0) ? 0 : ((x > 255) ? 255 : x);
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Compare one result against the arithmetic model.
    task automatic compare(input pend_t p);
        int sy, su, sv, ry, ru, rv;
        string tu, tv;
        sy = 9798 * p.r + 19235 * p.g + 3736 * p.b;
        su = -4784 * p.r - 9437 * p.g + 14221 * p.b;
        sv = 20218 * p.r - 16941 * p.g - 3277 * p.b;
        ry = sy >>> 15;
        ru = (su >>> 15) + 128;
        rv = (sv >>> 15) + 128;
        tu = (ru < 0 || ru > 255) ? "R7" : ((su < 0 && (su % 32768) != 0) ? "R9" : "R5");
        tv = (rv < 0 || rv > 255) ? "R7" : ((sv < 0 && (sv % 32768) != 0) ? "R9" : "R6");
        // R4
        check(int'(out_y) == clamp8(ry), "R4 luma", out_y, clamp8(ry));
        check(int'(out_u) == clamp8(ru), tu, out_u, clamp8(ru));
        check(int'(out_v) == clamp8(rv), tv, out_v, clamp8(rv));
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            check(1'b0, "watchdog", cyc, 100000);
            summary();
            $finish;
        end
    end

    // Output monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (pend_q.size() == 0) begin
                    // R3
                    check(1'b0, "R3 unexpected output", 1, 0);
                end else begin
                    pend_t p;
                    p = pend_q.pop_front();
                    // R3
                    check(cyc == p.stamp + 3, "R3 latency", cyc - p.stamp, 3);
                    compare(p);
                end
                last_y = out_y;
                last_u = out_u;
                last_v = out_v;
            end else begin
                // R8
                check(int'(out_y) == last_y && int'(out_u) == last_u && int'(out_v) == last_v,
                      "R8 hold", {8'd0, out_y, out_u, out_v}, (last_y << 16) | (last_u << 8) | last_v);
            end
        end
    end

    task automatic drive(input bit v, input int r, input int g, input int b);
        pend_t p;
        @(negedge clk);
        in_valid = v;
        in_r     = 8'(r);
        in_g     = 8'(g);
        in_b     = 8'(b);
        if (v && in_ready) begin
            p.r     = r;
            p.g     = g;
            p.b     = b;
            p.stamp = cyc;
            pend_q.push_back(p);
        end
    endtask

    initial begin
        rst_n    = 1'b1;
        in_valid = 1'b0;
        in_r     = '0;
        in_g     = '0;
        in_b     = '0;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        check(!out_valid, "R1 out_valid", out_valid, 0);
        check(!in_ready, "R1 in_ready", in_ready, 0);
        check(out_y == 0 && out_u == 0 && out_v == 0, "R1 data",
              {8'd0, out_y, out_u, out_v}, 0);
        rst_n  = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        // R2
        check(in_ready, "R2 ready after reset", in_ready, 1);

        // Directed corners: black, white, red (R7 high), cyan (R7 low), R9 near-black, grey
        drive(1'b1, 0, 0, 0);
        drive(1'b1, 255, 255, 255);
        drive(1'b1, 255, 0, 0);
        drive(1'b1, 0, 255, 255);
        drive(1'b1, 1, 0, 0);
        drive(1'b1, 77, 77, 77);
        drive(1'b0, 0, 0, 0);
        drive(1'b1, 0, 0, 255);
        drive(1'b1, 0, 255, 0);

        // Grid sweep, every axis including 0 and 255
        for (int r = 0; r < 256; r += 17) begin
            for (int g = 0; g < 256; g += 17) begin
                for (int b = 0; b < 256; b += 17) begin
                    drive(1'b1, r, g, b);
                end
            end
        end

        // Random pixels with random idle gaps
        for (int i = 0; i < 1500; i++) begin
            drive(($urandom % 4) != 0, $urandom % 256, $urandom % 256, $urandom % 256);
            // R2
            if (i % 100 == 0) check(in_ready, "R2 ready", in_ready, 1);
        end

        drive(1'b0, 0, 0, 0);
        repeat (6) @(negedge clk);
        // R3: every accepted pixel came out
        check(pend_q.size() == 0, "R3 drained", pend_q.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule